// File: doc/BRIEF.md
# Millisecond interval timer

This block produces a periodic interrupt whose period is a whole number of milliseconds. A cycle prescaler, sized by the parameter `CYCLES_PER_MS`, turns the system clock into one-millisecond ticks. A period counter then counts those ticks up to a programmed reload value. The period is therefore the reload value plus one, in milliseconds. When a period expires, the interrupt line goes high and stays high, and the next period starts with no software action.

Software reaches the block through a 32-bit register port with two word offsets. Writing the reload offset stores a new period value, drops any pending interrupt and restarts timing from zero. Reading the acknowledge offset returns zero and drops the interrupt. The reload offset can also be read back. Address bits [1:0] are ignored. If both `bus_wr` and `bus_rd` are high in the same cycle, the write takes precedence.

Top module: `ms_interval_timer`

## Requirements
- R1: After reset the interrupt is low and the reload value reads back as zero.
- R2: The interrupt rises exactly (reload+1)*CYCLES_PER_MS clock edges after the edge that samples a reload write.
- R3: After each expiry the next period starts at once, so with no software action the expiries repeat every (reload+1)*CYCLES_PER_MS edges.
- R4: The interrupt is a level. Once high, it stays high until an acknowledge read or a reload write.
- R5: A read at the acknowledge offset (0x230) returns zero. When it is not coincident with an expiry, it clears the interrupt on the next edge.
- R6: A write at the reload offset (0x228) stores the low RELOAD_W bits of the write data, clears the interrupt and restarts the period from zero.
- R7: When an acknowledge read and an expiry fall on the same edge, the interrupt stays high.
- R8: A read at the reload offset returns the stored reload value, zero-extended. A read at any other offset returns zero and leaves the interrupt unchanged.
- R9: A write at any offset other than 0x228 changes neither the reload value nor the interrupt.
- R10: Once reset is released, the default reload of zero gives a period of one millisecond, so the first interrupt rises CYCLES_PER_MS edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| timer_irq | output | 1 | Periodic interrupt level |

## Verification
On every cycle, the assertions check four local rules. Each count stays inside its range. The interrupt rises only on the edge after an expiry. It is cleared on the edge after a reload write, or after an acknowledge that does not meet an expiry. It holds its level when neither strobe is present.

Only the bench's scenarios can show the values that depend on history. These are:
- the exact period for each reload value;
- that the period repeats;
- the truncation of wide write data;
- that writes and reads at other offsets are ignored;
- the case where an acknowledge meets an expiry.

The bench sweeps the reload values 0 to 15 with a four-cycle millisecond.

// File: rtl/ms_timer_pkg.sv
package ms_timer_pkg;

    // One decoded register-port operation per cycle
    typedef enum logic [1:0] {
        OP_NONE,
        OP_RELOAD_WR,
        OP_ACK_RD,
        OP_RELOAD_RD
    } bus_op_e;

endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
    parameter int CYCLES_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ms_tick
);
    localparam int PW = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYCLES_PER_MS - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } presc_t;

    presc_t st_d, st_q;

    assign ms_tick = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (restart || ms_tick) st_d.cnt = '0;
        else                    st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the cycle count never passes the last cycle of a millisecond
    p_presc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

endmodule

// File: rtl/ms_period_counter.sv
module ms_period_counter #(
    parameter int RELOAD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                ms_tick,
    input  logic [RELOAD_W-1:0] reload,
    output logic                expire
);
    typedef struct packed {
        logic [RELOAD_W-1:0] ms_cnt;
    } period_t;

    period_t st_d, st_q;

    // A restart in the same cycle cancels the expiry
    assign expire = ms_tick && (st_q.ms_cnt == reload) && !restart;

    always_comb begin
        st_d = st_q;
        if (restart || expire) st_d.ms_cnt = '0;
        else if (ms_tick)      st_d.ms_cnt = st_q.ms_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the millisecond count never runs past the reload value
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ms_cnt <= reload);

endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
    import ms_timer_pkg::*;
#(
    parameter int              CYCLES_PER_MS = 50000,
    parameter int              RELOAD_W      = 32,
    parameter int              ADDR_W        = 14,
    parameter logic [13:0]     RELOAD_OFS    = 14'h228,
    parameter logic [13:0]     ACK_OFS       = 14'h230
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              timer_irq
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] RELOAD_WORD = RELOAD_OFS[ADDR_W-1:2];
    localparam logic [WORD_W-1:0] ACK_WORD    = ACK_OFS[ADDR_W-1:2];

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic                irq;
    } top_t;

    top_t    st_d, st_q;
    bus_op_e op;
    logic    restart;
    logic    ms_tick;
    logic    expire;

    // Decode: a write takes precedence over a read in the same cycle
    always_comb begin
        op = OP_NONE;
        if (bus_wr) begin
            if (bus_addr[ADDR_W-1:2] == RELOAD_WORD) op = OP_RELOAD_WR;
        end else if (bus_rd) begin
            if (bus_addr[ADDR_W-1:2] == ACK_WORD)         op = OP_ACK_RD;
            else if (bus_addr[ADDR_W-1:2] == RELOAD_WORD) op = OP_RELOAD_RD;
        end
    end

    assign restart = (op == OP_RELOAD_WR);

    ms_prescaler #(.CYCLES_PER_MS(CYCLES_PER_MS)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ms_tick (ms_tick)
    );

    ms_period_counter #(.RELOAD_W(RELOAD_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ms_tick (ms_tick),
        .reload  (st_q.reload),
        .expire  (expire)
    );

    // Priority: reload write clears, then expiry sets, then acknowledge clears
    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.reload = bus_wdata[RELOAD_W-1:0];
            st_d.irq    = 1'b0;
        end else if (expire) begin
            st_d.irq    = 1'b1;
        end else if (op == OP_ACK_RD) begin
            st_d.irq    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = (op == OP_RELOAD_RD) ? 32'(st_q.reload) : 32'd0;
    assign timer_irq = st_q.irq;

    p_wr_clears_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[ADDR_W-1:2] == RELOAD_WORD) |=> !timer_irq);

    p_ack_clears_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr[ADDR_W-1:2] == ACK_WORD && !expire) |=> !timer_irq);

    // R3 and R7: an expiry always leaves the line high, acknowledge or not
    p_expire_sets_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> timer_irq);

    p_rise_needs_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_irq) |-> $past(expire));

    p_level_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_irq && !bus_wr && !bus_rd) |=> timer_irq);

endmodule

// File: tb/tb_ms_interval_timer.sv
module tb_ms_interval_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 4;
    localparam int RW         = 8;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        timer_irq;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;

    ms_interval_timer #(.CYCLES_PER_MS(CPM), .RELOAD_W(RW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .timer_irq (timer_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Returns the cycle count seen at the negedge after the write edge
    task automatic do_write(input logic [13:0] a, input logic [31:0] d, output int t);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        t = cyc;
    endtask

    // Drives a read at the current negedge; returns data and leaves at next negedge
    task automatic do_read_now(input logic [13:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_rise(output int t);
        t = -1;
        for (int i = 0; i < 2000; i++) begin
            if (timer_irq) begin
                t = cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int t0, t1, t2;
        logic [31:0] rd;

        repeat (3) @(negedge clk);
        check("R1 irq in reset", int'(timer_irq), 0);
        rst_n = 1'b1;
        t0 = cyc;
        check("R1 irq after reset", int'(timer_irq), 0);
        wait_rise(t1);
        check("R10 first period after reset", t1 - t0, CPM);
        @(negedge clk);
        do_read_now(14'h228, rd);
        check("R1 reload after reset", int'(rd), 0);

        // Sweep every small reload value: first period, then a repeat period
        for (int r = 0; r < 16; r++) begin
            do_write(14'h228, 32'(r), t0);
            check("R6 write clears irq", int'(timer_irq), 0);
            wait_rise(t1);
            check("R2 period from write", t1 - t0, (r + 1) * CPM);
            do_read_now(14'h230, rd);
            check("R5 ack reads zero", int'(rd), 0);
            check("R5 ack clears irq", int'(timer_irq), 0);
            wait_rise(t2);
            check("R3 repeat period", t2 - t1, (r + 1) * CPM);
            do_read_now(14'h228, rd);
            check("R8 reload readback", int'(rd), r);
        end

        // Level hold with reload 2: stays high for several periods
        do_write(14'h228, 32'd2, t0);
        wait_rise(t1);
        repeat (4 * 3 * CPM) @(negedge clk);
        check("R4 level holds", int'(timer_irq), 1);

        // Other-offset read: zero data, interrupt untouched
        do_read_now(14'h234, rd);
        check("R8 other read data", int'(rd), 0);
        check("R8 other read keeps irq", int'(timer_irq), 1);

        // Other-offset writes ignored
        do_write(14'h22C, 32'd9, t0);
        check("R9 ignored write keeps irq", int'(timer_irq), 1);
        do_write(14'h230, 32'd9, t0);
        check("R9 write at ack offset keeps irq", int'(timer_irq), 1);
        do_read_now(14'h228, rd);
        check("R9 reload unchanged", int'(rd), 2);

        // Wide write data truncated to RELOAD_W bits; write clears a pending irq
        do_write(14'h228, 32'h0000_0103, t0);
        check("R6 write clears pending irq", int'(timer_irq), 0);
        wait_rise(t1);
        check("R6 truncated period", t1 - t0, 4 * CPM);
        do_read_now(14'h228, rd);
        check("R6 truncated readback", int'(rd), 3);

        // Restart mid-period: timing counts from the new write
        do_write(14'h228, 32'd5, t0);
        repeat (7) @(negedge clk);
        do_write(14'h229, 32'd1, t0);
        wait_rise(t1);
        check("R6 restart mid-period", t1 - t0, 2 * CPM);

        // Acknowledge on the same edge as an expiry: expiry wins
        do_write(14'h228, 32'd0, t0);
        wait_rise(t1);
        while (cyc != t1 + CPM - 1) @(negedge clk);
        do_read_now(14'h230, rd);
        check("R7 coincident ack keeps irq", int'(timer_irq), 1);
        do_read_now(14'h230, rd);
        check("R5 ack away from expiry clears", int'(timer_irq), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule